// File: doc/BRIEF.md
# Host-Mapped Dual Digital I/O Port Register File

This block sits behind an 8-bit host data bus and owns two 8-bit bidirectional digital I/O ports plus one status LED pin. The host selects one of four registers with a 2-bit offset. Two of these registers hold the output latches for port A and port B. One holds the per-port direction bits. One holds the LED control bit, which the host can only write.

Each port switches as a whole between input and output, under a single direction bit. In output mode the port drives its latch onto the pins and enables every pin driver, and a host read returns the latch. In input mode the drivers are off, and a read returns the pin levels after a two-flop synchronizer. The LED pin is active low and is the inverse of its register bit. That bit resets to 1, so the LED is lit as soon as reset ends.

Top module: `dio_regs`

## Requirements
- R1: After reset both output latches and the direction register are 0 (every `pin_oe` bit low), and the LED bit is 1, so `led_pin` is 0.
- R2: When `wr_en` is high at a rising clock edge, offset 0 loads `wdata` into the port A latch (`pin_out[7:0]`) and offset 1 loads it into the port B latch (`pin_out[15:8]`). The new value is visible right after that edge.
- R3: Offset 3 is the direction register. Bit 0 controls port A and bit 1 controls port B, where 1 means output and 0 means input. All eight `pin_oe` bits of a port equal that port's direction bit.
- R4: While a port is in output mode, a read of its offset returns its latch, whatever the levels on its pins.
- R5: While a port is in input mode, a read of its offset returns `pin_in` as sampled two rising edges earlier: a level present at edge k appears on `rdata` just after edge k+1.
- R6: A write to offset 2 stores `wdata[0]` as the LED bit, and `led_pin` is its inverse. `wdata[7:1]` is ignored.
- R7: A read of offset 2 returns 0x00, and a read of offset 3 returns 0 in bits 7..2.
- R8: With `wr_en` low, no latch, direction bit or LED bit changes.
- R9: A latch accepts writes while its port is in input mode, and `pin_out` always carries the latch value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Qualified host write strobe |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational from addr and register state |
| pin_in | input | 16 | Pin levels; port A in [7:0], port B in [15:8] |
| pin_out | output | 16 | Latch values presented to the pin drivers |
| pin_oe | output | 16 | Per-pin driver enable, 1 = drive |
| led_pin | output | 1 | LED pin, low = lit |

## Verification
The bound checker tests on every clock edge the rules that hold in every cycle. These are the effect of each write on a latch, on the direction enables and on the LED pin. The checker also tests that nothing changes without a write strobe, that an output-mode read returns the latch, that the unused read bits are zero, and that an input-mode read equals the pin value from two edges earlier. The bench scenarios show the rest: the reset values; a latch written in input mode appearing once the port turns to output; a pin change reaching `rdata` only on the second edge; and the two ports switching direction independently. A cycle-level reference model checks all outputs after every edge.

// File: rtl/dio_pkg.sv
package dio_pkg;
    typedef enum logic [1:0] {
        OFS_PORT_A = 2'd0,
        OFS_PORT_B = 2'd1,
        OFS_LED    = 2'd2,
        OFS_DIR    = 2'd3
    } dio_ofs_e;

    localparam int unsigned NUM_PORTS = 2;
    localparam logic        LED_RESET = 1'b1;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dio_port.sv
module dio_port #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [WIDTH-1:0] wdata,
    input  logic             dir_out,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] rd_val
);
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] pin_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_sel) begin
            latch_q <= wdata;
        end
    end

    dio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    always_comb begin
        pin_out = latch_q;
        pin_oe  = {WIDTH{dir_out}};
        rd_val  = dir_out ? latch_q : pin_sync;
    end
endmodule

// File: rtl/dio_regs.sv
module dio_regs #(
    parameter int unsigned PORT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            addr,
    input  logic [PORT_W-1:0]     wdata,
    output logic [PORT_W-1:0]     rdata,
    input  logic [2*PORT_W-1:0]   pin_in,
    output logic [2*PORT_W-1:0]   pin_out,
    output logic [2*PORT_W-1:0]   pin_oe,
    output logic                  led_pin
);
    import dio_pkg::*;

    localparam int unsigned NP = NUM_PORTS;

    dio_ofs_e          ofs;
    logic [NP-1:0]     dir_q;
    logic              led_q;
    logic [PORT_W-1:0] port_rd [NP];

    assign ofs = dio_ofs_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            led_q <= LED_RESET;
        end else if (wr_en) begin
            if (ofs == OFS_DIR) dir_q <= wdata[NP-1:0];
            if (ofs == OFS_LED) led_q <= wdata[0];
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        logic sel;
        assign sel = wr_en && (addr == 2'(p));
        dio_port #(.WIDTH(PORT_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (sel),
            .wdata   (wdata),
            .dir_out (dir_q[p]),
            .pin_in  (pin_in [p*PORT_W +: PORT_W]),
            .pin_out (pin_out[p*PORT_W +: PORT_W]),
            .pin_oe  (pin_oe [p*PORT_W +: PORT_W]),
            .rd_val  (port_rd[p])
        );
    end

    assign led_pin = ~led_q;

    always_comb begin
        rdata = '0;
        unique case (ofs)
            OFS_PORT_A: rdata = port_rd[0];
            OFS_PORT_B: rdata = port_rd[1];
            OFS_LED:    rdata = '0;
            OFS_DIR:    rdata[NP-1:0] = dir_q;
        endcase
    end
endmodule

// File: rtl/dio_regs_chk.sv
module dio_regs_chk #(
    parameter int unsigned PORT_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          addr,
    input logic [PORT_W-1:0]   wdata,
    input logic [PORT_W-1:0]   rdata,
    input logic [2*PORT_W-1:0] pin_in,
    input logic [2*PORT_W-1:0] pin_out,
    input logic [2*PORT_W-1:0] pin_oe,
    input logic                led_pin
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_write_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> pin_out[PORT_W-1:0] == $past(wdata));

    p_write_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> pin_out[2*PORT_W-1:PORT_W] == $past(wdata));

    p_dir_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3) |=>
            (pin_oe[0] == $past(wdata[0])) && (pin_oe[PORT_W] == $past(wdata[1])));

    p_out_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd0 && pin_oe[0]) |-> rdata == pin_out[PORT_W-1:0]);

    p_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && addr == 2'd0 && !pin_oe[0] && $past(!pin_oe[0]))
            |-> rdata == $past(pin_in[PORT_W-1:0], 2));

    p_led_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2) |=> led_pin == !$past(wdata[0]));

    p_zero_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr == 2'd2) |-> rdata == '0) and
        ((addr == 2'd3) |-> rdata[PORT_W-1:2] == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pin_out) && $stable(pin_oe) && $stable(led_pin));
endmodule

bind dio_regs dio_regs_chk #(.PORT_W(PORT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .led_pin(led_pin)
);

// File: tb/tb_dio_regs.sv
`timescale 1ns/1ps
module tb_dio_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic [15:0] pin_in = 16'd0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        led_pin;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    int          m_a, m_b, m_dir, m_led;
    logic [15:0] hist[$];

    always #2.5 clk = ~clk;

    dio_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .led_pin(led_pin)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_rd(input int a);
        logic [15:0] s;
        s = hist[0];
        case (a)
            0: return m_dir[0] ? m_a : int'(s[7:0]);
            1: return m_dir[1] ? m_b : int'(s[15:8]);
            2: return 0;
            default: return m_dir & 3;
        endcase
    endfunction

    function automatic string rd_req(input int a);
        if (a == 2 || a == 3) return "R7";
        if (m_dir[a]) return "R4";
        return "R5";
    endfunction

    task automatic model_reset();
        m_a = 0; m_b = 0; m_dir = 0; m_led = 1;
        hist.delete();
        hist.push_back(16'd0);
        hist.push_back(16'd0);
    endtask

    task automatic compare_all();
        chk("R9", int'(pin_out[7:0]), m_a);
        chk("R2", int'(pin_out[15:8]), m_b);
        chk("R3", int'(pin_oe), (m_dir[0] ? 'h00FF : 0) | (m_dir[1] ? 'hFF00 : 0));
        chk("R6", int'(led_pin), m_led ? 0 : 1);
        chk(rd_req(addr), int'(rdata), exp_rd(addr));
    endtask

    // drive at negedge, clock once, update model, compare at next negedge
    task automatic step(input bit we, input int a, input int d, input int pins);
        wr_en = we; addr = 2'(a); wdata = 8'(d); pin_in = 16'(pins);
        @(posedge clk);
        if (we) begin
            case (a)
                0: m_a = d & 'hFF;
                1: m_b = d & 'hFF;
                2: m_led = d & 1;
                default: m_dir = d & 3;
            endcase
        end
        hist.push_back(pin_in);
        void'(hist.pop_front());
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk("R1", int'(pin_oe), 0);
        chk("R1", int'(pin_out), 0);
        chk("R1", int'(led_pin), 0);
        for (int a = 0; a < 4; a++) begin
            addr = 2'(a); #0.1;
            chk("R1", int'(rdata), 0);
        end
        // R9: latch written in input mode
        step(1, 0, 'h5A, 0);
        chk("R9", int'(pin_out[7:0]), 'h5A);
        chk("R3", int'(pin_oe), 0);
        // R5: pin change reaches rdata on second edge
        step(0, 0, 0, 'h00C3);
        chk("R5", int'(rdata), 'h00);
        step(0, 0, 0, 'h00C3);
        chk("R5", int'(rdata), 'hC3);
        // R4: switch A to output, read returns latch not pins
        step(1, 3, 'h01, 'h00C3);
        step(0, 0, 0, 'h00C3);
        chk("R4", int'(rdata), 'h5A);
        chk("R3", int'(pin_oe), 'h00FF);
        // R7: unused dir bits read 0
        step(1, 3, 'hFF, 'h00C3);
        step(0, 3, 0, 'h00C3);
        chk("R7", int'(rdata), 'h03);
        // R2: port B write and read in output mode
        step(1, 1, 'h81, 'h3C00);
        step(0, 1, 0, 'h3C00);
        chk("R2", int'(rdata), 'h81);
        chk("R2", int'(pin_out[15:8]), 'h81);
        // R6: LED off then on, upper bits ignored
        step(1, 2, 'hFE, 0);
        chk("R6", int'(led_pin), 1);
        step(1, 2, 'h01, 0);
        chk("R6", int'(led_pin), 0);
        step(0, 2, 0, 0);
        chk("R7", int'(rdata), 0);
        // R8: no effect without strobe
        step(0, 0, 'hFF, 0);
        step(0, 3, 'h00, 0);
        step(0, 2, 'h00, 0);
        chk("R8", int'(pin_out), 'h815A);
        chk("R8", int'(pin_oe), 'hFFFF);
        chk("R8", int'(led_pin), 0);
        // R3: B back to input independently, B pins sampled
        step(1, 3, 'h01, 'hA500);
        step(0, 1, 0, 'hA500);
        chk("R5", int'(rdata), 'hA5);
        chk("R3", int'(pin_oe), 'h00FF);
        for (int i = 0; i < 40; i++) begin
            step(i % 5 == 0, i % 4, (i * 37) & 'hFF, (i * 4099) & 'hFFFF);
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule